// File: doc/BRIEF.md
# Edge-Event GPIO Input Port

This block samples a parameterised number of external input pins into a register that software can read. Each pin can raise an event on a rising edge, on a falling edge, or on any change. Software picks the trigger for each pin with two bits: a mode bit and an edge bit. Detected events latch into a pending register. An enable register decides which pending bits drive one level-sensitive interrupt output. Software acknowledges events by writing ones to the pending register.

The port is input-only, and this is fixed when the design is built. The block has no output drive and no direction control. Register access uses a simple strobe bus: `csr_sel` with `csr_we` starts an access in the cycle it is sampled. Read data appears on `csr_rdata` in the following cycle and is zero in every other cycle. Each logical register is `N_PINS` bits wide. It is split into `NSUB = ceil(N_PINS/CSR_DW)` subregisters of `CSR_DW` bits, and each subregister occupies one 32-bit-aligned word slot. Because `NSUB` is derived from the two parameters, the pins always fit in the subregisters.

Top module: `gpio_evt_in`

## Requirements
- R1: After reset, the mode, edge, pending and enable registers read zero, `irq` is 0 and `csr_rdata` is 0.
- R2: The register index is `csr_addr / NSUB` and the subregister is `csr_addr % NSUB`. Subregister 0 holds pin bits `[CSR_DW-1:0]`. The indices are: 0 input, 1 mode, 2 edge, 3 pending, 4 enable. Reading the input register returns the pin levels after a two-flop synchroniser. Bits at or above `N_PINS` read as zero.
- R3: With mode bit 0 and edge bit 0, a pin sets its pending bit on a 0-to-1 transition only.
- R4: With mode bit 0 and edge bit 1, a pin sets its pending bit on a 1-to-0 transition only.
- R5: With mode bit 1, a pin sets its pending bit on both transitions, whatever its edge bit.
- R6: A detected event sets its pending bit whether or not the pin is enabled. A pending bit whose enable bit is 0 never asserts `irq`.
- R7: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If an event and a clear reach the same bit in the same cycle, the bit stays set.
- R8: `irq` is the registered OR of pending AND enable. It rises 4 clock edges after a pin change sampled at the first edge. It stays high until every enabled pending bit has been cleared.
- R9: Pin levels present at reset release cause no event.
- R10: A read returns data on the cycle after the strobe, and `csr_rdata` is zero otherwise. Written bits at or above `N_PINS` are dropped and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gpio_i | input | N_PINS | Asynchronous input pins |
| csr_sel | input | 1 | Register access strobe |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_addr | input | AW | Word slot index |
| csr_wdata | input | CSR_DW | Write data |
| csr_rdata | output | CSR_DW | Read data, one cycle after a read strobe |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with 12 pins and an 8-bit data width. This gives two subregisters per register, and the upper one is only half populated. With these values, the bench can check that pin bits are split across word slots. It can also check that the four unimplemented upper bits are dropped on write and read as zero. A pin in the upper subregister is given a falling trigger, so edge detection is exercised on both slots. The bench also times one interrupt to the exact cycle and lands a clear write on the same edge as a new event.

// File: rtl/gpio_evt_in.sv
module gpio_evt_in #(
  parameter int N_PINS = 12,
  parameter int CSR_DW = 8,
  localparam int NSUB = (N_PINS + CSR_DW - 1) / CSR_DW,
  localparam int AW   = (5 * NSUB > 1) ? $clog2(5 * NSUB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] gpio_i,
  input  logic              csr_sel,
  input  logic              csr_we,
  input  logic [AW-1:0]     csr_addr,
  input  logic [CSR_DW-1:0] csr_wdata,
  output logic [CSR_DW-1:0] csr_rdata,
  output logic              irq
);
  localparam int PW = NSUB * CSR_DW;

  logic [N_PINS-1:0] s1, s2, prev;
  logic [N_PINS-1:0] mode_r, edge_r, pend_r, en_r;
  logic [1:0]        warm;
  logic              ready;

  logic [AW-1:0]     reg_idx, sub;
  logic [PW-1:0]     wr_bits, wr_mask, rd_full;
  logic [N_PINS-1:0] wb, wm;
  logic              wr_on, rd_on;

  logic [N_PINS-1:0] rise, fall, ev, ev_set, clr;

  assign reg_idx = AW'(32'(csr_addr) / NSUB);
  assign sub     = AW'(32'(csr_addr) % NSUB);
  assign wr_on   = csr_sel & csr_we;
  assign rd_on   = csr_sel & ~csr_we;

  always_comb begin
    wr_bits = PW'(csr_wdata) << (32'(sub) * CSR_DW);
    wr_mask = PW'({CSR_DW{1'b1}}) << (32'(sub) * CSR_DW);
  end
  assign wb = wr_bits[N_PINS-1:0];
  assign wm = wr_mask[N_PINS-1:0];

  // synchroniser and history; events held off until history holds a real sample
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
      warm <= '0;
    end else begin
      s1   <= gpio_i;
      s2   <= s1;
      prev <= s2;
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end
  assign ready = (warm == 2'd3);

  assign rise = s2 & ~prev;
  assign fall = ~s2 & prev;

  genvar g;
  generate
    for (g = 0; g < N_PINS; g++) begin : g_pin
      assign ev[g] = mode_r[g] ? (rise[g] | fall[g])
                               : (edge_r[g] ? fall[g] : rise[g]);
    end
  endgenerate

  assign ev_set = ready ? ev : '0;
  assign clr    = (wr_on && reg_idx == AW'(3)) ? (wb & wm) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_r <= '0;
      edge_r <= '0;
      en_r   <= '0;
      pend_r <= '0;
    end else begin
      if (wr_on && reg_idx == AW'(1)) mode_r <= (mode_r & ~wm) | (wb & wm);
      if (wr_on && reg_idx == AW'(2)) edge_r <= (edge_r & ~wm) | (wb & wm);
      if (wr_on && reg_idx == AW'(4)) en_r   <= (en_r & ~wm) | (wb & wm);
      pend_r <= (pend_r & ~clr) | ev_set;
    end
  end

  always_comb begin
    unique case (reg_idx)
      AW'(0):  rd_full = PW'(s2);
      AW'(1):  rd_full = PW'(mode_r);
      AW'(2):  rd_full = PW'(edge_r);
      AW'(3):  rd_full = PW'(pend_r);
      AW'(4):  rd_full = PW'(en_r);
      default: rd_full = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      csr_rdata <= rd_on ? CSR_DW'(rd_full >> (32'(sub) * CSR_DW)) : '0;
      irq       <= |(pend_r & en_r);
    end
  end

  // a newly set pending bit needs a seen transition on that pin
  p_pend_needs_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    |(pend_r & ~$past(pend_r)) |-> (($past(s2) ^ $past(prev)) & pend_r & ~$past(pend_r)) != '0);

  // nothing pends while the history is being primed
  p_quiet_prime_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> pend_r == '0);

  // set beats clear on a coinciding event
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_set != '0) |-> ((pend_r & $past(ev_set)) == $past(ev_set)));

  // cleared bits with no event are gone next cycle
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr != '0) |-> (pend_r & $past(clr & ~ev_set)) == '0);

  // interrupt drops only after no enabled pending bit remains
  p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(pend_r & en_r) == '0));

  // read data is zero unless a read was strobed
  p_rdata_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rdata != '0) |-> $past(rd_on));
endmodule

// File: tb/gpio_evt_in_tb_top.sv
`timescale 1ns/1ps
module gpio_evt_in_tb_top;
  localparam int N  = 12;
  localparam int DW = 8;
  localparam int AW = 4;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [N-1:0]  pins = 12'hA5A;
  logic          csr_sel = 0, csr_we = 0;
  logic [AW-1:0] csr_addr = '0;
  logic [DW-1:0] csr_wdata = '0;
  logic [DW-1:0] csr_rdata;
  logic          irq;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  logic          rd_seen = 0;

  logic [N-1:0] m_mode = '0, m_edge = '0, m_pend = '0;

  always #10 clk = ~clk;

  gpio_evt_in #(.N_PINS(N), .CSR_DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .gpio_i(pins), .csr_sel(csr_sel), .csr_we(csr_we),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= csr_sel && !csr_we;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("scoreboard", 1, 0);
      else check(tag_q.pop_front(), csr_rdata, exp_q.pop_front());
    end
  end

  task automatic rd(input int addr, input logic [DW-1:0] exp, input string req);
    @(negedge clk);
    csr_sel = 1; csr_we = 0; csr_addr = AW'(addr);
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    csr_sel = 0;
  endtask

  task automatic wr(input int addr, input logic [DW-1:0] data);
    @(negedge clk);
    csr_sel = 1; csr_we = 1; csr_addr = AW'(addr); csr_wdata = data;
    @(negedge clk);
    csr_sel = 0; csr_we = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [N-1:0] events(input logic [N-1:0] o, input logic [N-1:0] n);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (m_mode[i]) r[i] = o[i] ^ n[i];
      else if (m_edge[i]) r[i] = o[i] & ~n[i];
      else r[i] = ~o[i] & n[i];
    end
    return r;
  endfunction

  task automatic set_pins(input logic [N-1:0] v);
    @(negedge clk);
    m_pend |= events(pins, v);
    pins = v;
    idle(6);
  endtask

  task automatic rd_pend(input string req);
    rd(6, m_pend[7:0], req);
    rd(7, {4'b0, m_pend[11:8]}, req);
  endtask

  task automatic clr_pend(input int addr, input logic [DW-1:0] v);
    wr(addr, v);
    if (addr == 6) m_pend[7:0] &= ~v; else m_pend[11:8] &= ~v[3:0];
    idle(3);
  endtask

  initial begin
    idle(5);
    rst_n = 1;
    idle(10);
    check("R1 irq after reset", irq, 0);
    check("R10 idle rdata", csr_rdata, 0);
    rd(2, 8'h00, "R1 mode");
    rd(4, 8'h00, "R1 edge");
    rd(8, 8'h00, "R1 enable");
    rd_pend("R9 no event from reset levels");
    rd(0, 8'h5A, "R2 input low slot");
    rd(1, 8'h0A, "R2 input high slot, upper bits zero");

    set_pins('0);
    rd_pend("R3 falling ignored under default rising");

    wr(2, 8'h04); m_mode[7:0] = 8'h04;
    wr(4, 8'h02); m_edge[7:0] = 8'h02;
    wr(5, 8'hF2); m_edge[11:8] = 4'h2;
    rd(5, 8'h02, "R10 bits above N dropped");
    rd(2, 8'h04, "R2 mode readback");

    set_pins(12'h007);
    rd_pend("R3 R4 R5 rising pattern");
    set_pins(12'h200);
    rd_pend("R4 R5 falling pattern");
    set_pins(12'h000);
    rd_pend("R4 high slot falling");
    check("R6 no irq while disabled", irq, 0);

    clr_pend(6, 8'h00);
    rd_pend("R7 zero write leaves pending");
    wr(8, 8'h05);
    idle(3);
    check("R6 irq once enabled", irq, 1);
    clr_pend(6, 8'h01);
    check("R8 irq held by other enabled bit", irq, 1);
    rd_pend("R7 single bit cleared");
    clr_pend(6, 8'h04);
    check("R8 irq low after all enabled cleared", irq, 0);
    clr_pend(6, 8'hFF);
    clr_pend(7, 8'hFF);
    rd_pend("R7 all cleared");

    // exact latency: change at negedge 0, irq after edge 4
    @(negedge clk);
    pins[0] = 1'b1; m_pend[0] = 1'b1;
    idle(3);
    check("R8 irq not yet after 3 edges", irq, 0);
    idle(1);
    check("R8 irq after 4 edges", irq, 1);

    // pin2 pending already set by a new event; then clear coincides with next one
    set_pins(12'h005);
    rd_pend("R5 pin2 pending");
    @(negedge clk);
    pins[2] = 1'b0;
    idle(2);
    csr_sel = 1; csr_we = 1; csr_addr = AW'(6); csr_wdata = 8'h04;
    @(negedge clk);
    csr_sel = 0; csr_we = 0;
    idle(3);
    rd_pend("R7 set wins over clear");

    idle(4);
    check("scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule